// File: doc/BRIEF.md
# I2C Byte-at-a-Time Master

This block is an I2C bus master that moves one byte per software handshake. Software reaches it through four byte-wide registers: control, status, target address and a data port. Writing the control register with both the interface-enable and start-enable bits set makes the engine issue a START condition and clock out the target address with its direction bit. It then stops with SCL held low and raises a status flag.

From then on, each byte is released by software clearing that flag. In the write direction the engine sends the byte held in the data port. In the read direction it receives a byte, which software then reads back from the data port. A force-stop control bit ends the transfer. In the write direction it ends it at once from the hold point. In the read direction it ends it after the byte in progress, which is answered with NACK.

Acknowledge failures, lost arbitration and the completed STOP are reported through sticky status flags. A pin-override mode lets software drive both bus lines directly, for example to clock a stuck target free. Both bus lines are open-drain: the block only ever pulls a line low or releases it.

Top module: `i2c_byte_master`

## Requirements
- R1: `reg_addr` selects the register: 0 control, 1 status, 2 target address, 3 data port. Control and address read back what was written. A status read has bit 7 at 0. The data port is write-only for transmit data, and reading it returns the last received byte. All registers are 0 after reset.
- R2: A control write with bit 3 (interface enable) and bit 0 (start enable) both set, while the engine is idle, produces a START. The engine then shifts the address register out MSB first: bits 7:1 are the 7-bit target and bit 0 is the direction, with 1 meaning read. A control write without bit 3 produces no START.
- R3: After the address byte's acknowledge clock, the engine sets status bit 0, plus bit 1 for a read or bit 3 for a write. If the target did not acknowledge, it also sets bit 6. It then holds SCL low.
- R4: Status flags are sticky. A write to status clears each bit written as 0 and keeps each bit written as 1. A flag set by the engine in the same cycle wins. Nothing else clears a flag.
- R5: In the write direction, while holding with force-stop (control bit 1) clear, clearing status bit 3 sends the data-port byte and then sets bit 3 again. A byte that is not acknowledged also sets bit 6.
- R6: In the read direction, clearing status bit 1 while holding receives one byte MSB first and then sets bit 1. The byte is readable at the data port, and the engine answers it with ACK when force-stop was clear at the byte's start.
- R7: A byte received while force-stop is set is answered with NACK. The engine then issues a STOP and sets status bit 4.
- R8: While holding with force-stop set, and with either the write direction or status bit 6 set, the engine issues a STOP without any further byte. It then sets status bit 4 and releases both lines.
- R9: When a transmitted 1 is sampled low on SDA, the engine releases both lines, sets status bit 5 and returns to idle without setting any phase-done flag.
- R10: Any control write with bit 3 clear returns the engine to idle at once and releases both lines (outside pin override).
- R11: With control bit 4 set, SCL is released when control bit 6 is 1 and pulled low when it is 0. SDA follows control bit 5 the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench attaches a behavioural target and runs random-length writes and reads. It then goes after the edges of the protocol.

- **Single-byte read.** This byte must be NACKed and followed by STOP. A design that latched force-stop too late would ACK it and leave the target driving SDA.
- **Address NACK.** This is tested in both directions, where STOP must come straight from the hold point. A design that waited on the direction flag would hang with SCL low.
- **NACK on a middle write byte.** The sticky bit must survive later acknowledged bytes.
- **Abort mid-address.** Both lines must float at once.
- **Arbitration loss on the first released address bit.** A design that kept driving would corrupt the other master's frame.
- **Writing ones to status.** This must set nothing, and a design that stored the written value would invent events.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QDIV = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int CW = $clog2(QDIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_STOP} st_t;
  st_t st;

  logic [7:0]    ctl, adr, txd, rxd, sh;
  logic [6:0]    sts, sts_set;
  logic [CW-1:0] cnt;
  logic [1:0]    q;
  logic [3:0]    bi;
  logic          is_adr, is_tx, last, ackd;

  logic busy, tick, qend, smp, dir_rd, wr_ctl, wr_sts, go, kill, lost, byte_end;

  assign dir_rd   = adr[0];
  assign busy     = (st == S_START) || (st == S_BIT) || (st == S_STOP);
  assign tick     = busy && (cnt == CW'(QDIV - 1));
  assign smp      = tick && (q == 2'd2);
  assign qend     = tick && (q == 2'd3);
  assign wr_ctl   = reg_wr && (reg_addr == 2'd0);
  assign wr_sts   = reg_wr && (reg_addr == 2'd1);
  assign go       = wr_ctl && reg_wdata[3] && reg_wdata[0] && (st == S_IDLE);
  assign kill     = wr_ctl && !reg_wdata[3];
  assign lost     = (st == S_BIT) && is_tx && (bi != 4'd8) && smp && sh[7] && !sda_in;
  assign byte_end = (st == S_BIT) && qend && (bi == 4'd8);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctl;
      2'd1:    reg_rdata = {1'b0, sts};
      2'd2:    reg_rdata = adr;
      default: reg_rdata = rxd;
    endcase
  end

  always_comb begin
    sts_set = '0;
    if (lost) sts_set[5] = 1'b1;
    if ((st == S_STOP) && qend) sts_set[4] = 1'b1;
    if (byte_end) begin
      if (is_adr) begin
        sts_set[0] = 1'b1;
        sts_set[6] = !ackd;
        if (dir_rd) sts_set[1] = 1'b1;
        else        sts_set[3] = 1'b1;
      end else if (is_tx) begin
        sts_set[3] = 1'b1;
        sts_set[6] = !ackd;
      end else begin
        sts_set[1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      adr <= '0;
      txd <= '0;
      sts <= '0;
    end else begin
      if (wr_ctl) ctl <= reg_wdata;
      if (reg_wr && (reg_addr == 2'd2)) adr <= reg_wdata;
      if (reg_wr && (reg_addr == 2'd3)) txd <= reg_wdata;
      sts <= (wr_sts ? (sts & reg_wdata[6:0]) : sts) | sts_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= '0;
    end else begin
      cnt <= (!busy || tick) ? '0 : cnt + 1'b1;
      if (!busy)     q <= '0;
      else if (tick) q <= q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      rxd    <= '0;
      bi     <= '0;
      is_adr <= 1'b0;
      is_tx  <= 1'b0;
      last   <= 1'b0;
      ackd   <= 1'b0;
    end else if (kill || lost) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st     <= S_START;
          sh     <= adr;
          bi     <= '0;
          is_adr <= 1'b1;
          is_tx  <= 1'b1;
        end
        S_START: if (qend) st <= S_BIT;
        S_BIT: begin
          if (smp) begin
            if (bi == 4'd8) ackd <= !sda_in;
            else if (!is_tx) sh <= {sh[6:0], sda_in};
          end
          if (qend) begin
            if (bi != 4'd8) begin
              bi <= bi + 4'd1;
              if (is_tx) sh <= {sh[6:0], 1'b0};
            end else begin
              bi <= '0;
              if (!is_tx) rxd <= sh;
              st <= (!is_tx && last) ? S_STOP : S_HOLD;
            end
          end
        end
        S_HOLD: begin
          if (ctl[1] && (!dir_rd || sts[6])) begin
            st <= S_STOP;
          end else if (dir_rd && !sts[1]) begin
            st     <= S_BIT;
            is_adr <= 1'b0;
            is_tx  <= 1'b0;
            last   <= ctl[1];
          end else if (!dir_rd && !sts[3]) begin
            st     <= S_BIT;
            is_adr <= 1'b0;
            is_tx  <= 1'b1;
            sh     <= txd;
          end
        end
        S_STOP: if (qend) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      S_START: begin
        sda_low = (q != 2'd0);
        scl_low = (q == 2'd3);
      end
      S_BIT: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        if (bi == 4'd8) sda_low = !is_tx && !last;
        else            sda_low = is_tx && !sh[7];
      end
      S_HOLD: scl_low = 1'b1;
      S_STOP: begin
        scl_low = (q == 2'd0);
        sda_low = (q == 2'd0) || (q == 2'd1);
      end
      default: ;
    endcase
    if (ctl[4]) begin
      scl_low = !ctl[6];
      sda_low = !ctl[5];
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       scl_low,
  input logic       sda_low,
  input logic [6:0] sts,
  input logic       ovr
);
  a_r4_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> ((sts & $past(sts)) == $past(sts)));

  a_r10_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !reg_wdata[3] && !reg_wdata[4]) |=> (!scl_low && !sda_low));

  a_r9_lost_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts[5]) && !ovr) |-> (!scl_low && !sda_low));

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts[4]) && !ovr) |-> (!scl_low && !sda_low));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts[0]) && !ovr) |-> scl_low);

  a_r6_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(sts[1]) || $rose(sts[3])) && !ovr) |-> scl_low);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .scl_low(scl_low), .sda_low(sda_low),
  .sts(sts), .ovr(ctl[4])
);

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/100ps
module tb_i2c_byte_master;
  localparam logic [6:0] SA = 7'h3C;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_low, sda_low, s_drive = 1'b0, arb_force = 1'b0;
  logic scl_bus, sda_bus;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_bus = !scl_low;
  assign sda_bus = !sda_low && !s_drive && !arb_force;

  i2c_byte_master #(.QDIV(3)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_bus),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  // behavioural target
  logic ps = 1'b1, pd = 1'b1, cs, cd;
  logic s_act = 0, s_wait = 0, s_adr = 0, s_sel = 0, s_rd = 0, s_tx = 0, s_done = 0;
  logic [7:0] s_sh = '0, s_txb = '0, s_rbase = '0;
  logic [7:0] s_wlog [16];
  int s_cnt = 0, s_wn = 0, s_ti = 0, s_acks = 0, s_nacks = 0, s_starts = 0, s_stops = 0, nack_at = -1;

  function automatic logic [7:0] rbyte(input logic [7:0] base, input int i);
    return base ^ 8'(i * 37);
  endfunction

  always @(negedge clk) begin
    cs = scl_bus; cd = sda_bus;
    if (!rst_n) begin
      s_act = 0; s_drive = 0;
    end else if (ps && cs && pd && !cd) begin
      s_act = 1; s_wait = 1; s_cnt = 0; s_adr = 1; s_sel = 0; s_tx = 0; s_done = 0;
      s_drive = 0; s_wn = 0; s_ti = 0; s_acks = 0; s_nacks = 0; s_starts++;
    end else if (ps && cs && !pd && cd) begin
      if (s_act) s_stops++;
      s_act = 0; s_drive = 0;
    end else if (s_act && !ps && cs) begin
      if (s_cnt < 8) s_sh = {s_sh[6:0], cd};
      else if (s_tx) begin
        if (cd) begin s_nacks++; s_done = 1; end
        else s_acks++;
      end
    end else if (s_act && ps && !cs) begin
      if (s_wait) s_wait = 0;
      else begin
        s_cnt = (s_cnt == 8) ? 0 : s_cnt + 1;
        if (s_cnt == 8) begin
          if (s_adr) begin
            s_sel = (s_sh[7:1] == SA); s_rd = s_sh[0]; s_drive = s_sel;
          end else if (s_sel && !s_rd) begin
            s_wlog[s_wn & 15] = s_sh; s_drive = (s_wn != nack_at); s_wn++;
          end else s_drive = 0;
        end else if (s_cnt == 0) begin
          s_adr = 0;
          s_tx = s_sel && s_rd && !s_done;
          if (s_tx) begin s_txb = rbyte(s_rbase, s_ti); s_ti++; s_drive = !s_txb[7]; end
          else s_drive = 0;
        end else s_drive = s_tx && !s_txb[7 - s_cnt];
      end
    end
    ps = cs; pd = cd;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_sts(input logic [7:0] m, input string tag, output logic [7:0] v);
    int n = 0;
    v = '0;
    while (((v & m) == 0) && n < 4000) begin rd(2'd1, v); n++; end
    if (n >= 4000) chk(1'b0, tag, v, m);
  endtask

  task automatic do_write(input int len, input int nk);
    logic [7:0] v, d;
    int st0, sp0;
    nack_at = nk; st0 = s_starts; sp0 = s_stops;
    wr(2, {SA, 1'b0}); wr(1, 0); wr(0, 8'h89);
    wait_sts(8'h01, "R3 wait", v);
    chk(v == 8'h09, "R3 write address status", v, 8'h09);
    chk(scl_low, "R3 SCL held low", scl_low, 1);
    chk(s_starts == st0 + 1 && s_sel, "R2 start and address seen", s_starts - st0, 1);
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      wr(3, d); wr(1, 8'hF7);
      rd(1, v);
      chk(!v[3] && v[0], "R4 only written-zero flag cleared", v, 8'h01);
      wait_sts(8'h08, "R5 wait", v);
      chk(s_wlog[i] == d, "R5 byte on wire", s_wlog[i], d);
      chk(v[6] == (nk >= 0 && i >= nk), "R5 data nack flag", v[6], (nk >= 0 && i >= nk));
    end
    wr(0, 8'h8A);
    wait_sts(8'h10, "R8 wait", v);
    chk(s_stops == sp0 + 1, "R8 stop on wire", s_stops - sp0, 1);
    chk(!scl_low && !sda_low, "R8 lines released", {scl_low, sda_low}, 0);
    chk(s_wn == len, "R8 no extra byte", s_wn, len);
    wr(1, 0); rd(1, v);
    chk(v == 0, "R4 clear by zero write", v, 0);
    nack_at = -1;
  endtask

  task automatic do_read(input int len);
    logic [7:0] v;
    int sp0;
    sp0 = s_stops; s_rbase = 8'($urandom);
    wr(2, {SA, 1'b1}); wr(1, 0); wr(0, 8'h89);
    wait_sts(8'h01, "R3 wait", v);
    chk(v == 8'h03, "R3 read address status", v, 8'h03);
    for (int i = 0; i < len; i++) begin
      if (i == len - 1) wr(0, 8'h8A);
      wr(1, 8'hFD);
      wait_sts(8'h02, "R6 wait", v);
      rd(3, v);
      chk(v == rbyte(s_rbase, i), "R6 received byte", v, rbyte(s_rbase, i));
    end
    wait_sts(8'h10, "R7 wait", v);
    chk(s_acks == len - 1, "R6 bytes acknowledged", s_acks, len - 1);
    chk(s_nacks == 1, "R7 last byte NACKed", s_nacks, 1);
    chk(s_stops == sp0 + 1, "R7 stop after last byte", s_stops - sp0, 1);
    wr(1, 0);
  endtask

  task automatic do_addr_nack(input bit dir);
    logic [7:0] v;
    logic [7:0] e;
    e = dir ? 8'h43 : 8'h49;
    wr(2, {SA + 7'd1, dir}); wr(1, 0); wr(0, 8'h89);
    wait_sts(8'h01, "R3 wait", v);
    chk(v == e, "R3 address nack status", v, e);
    wr(0, 8'h8A);
    wait_sts(8'h10, "R8 wait", v);
    chk(!scl_low && !sda_low, "R8 stop after address nack", {scl_low, sda_low}, 0);
    wr(1, 0);
  endtask

  initial begin
    logic [7:0] v;
    int st0;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 reset value", v, 0);
    end
    chk(!scl_low && !sda_low, "R1 lines idle after reset", {scl_low, sda_low}, 0);
    wr(0, 8'h85); rd(0, v); chk(v == 8'h85, "R1 control readback", v, 8'h85);
    wr(2, 8'hA5); rd(2, v); chk(v == 8'hA5, "R1 address readback", v, 8'hA5);
    wr(3, 8'h3C); rd(3, v); chk(v == 8'h00, "R1 data port reads receive byte", v, 0);
    wr(1, 8'hFF); rd(1, v); chk(v == 8'h00, "R4 writing ones sets nothing", v, 0);
    st0 = s_starts;
    wr(0, 8'h81); repeat (100) @(negedge clk);
    chk(s_starts == st0 && !scl_low, "R2 no start without enable", s_starts - st0, 0);
    wr(0, 8'h00);

    do_read(1);
    do_addr_nack(1'b0);
    do_addr_nack(1'b1);
    for (int r = 0; r < 4; r++) begin
      int len;
      len = 1 + $urandom_range(3);
      if (r == 2) do_write(len + 1, 1);
      else do_write(len, -1);
      do_read(1 + $urandom_range(3));
    end

    wr(2, {SA, 1'b0}); wr(1, 0); wr(0, 8'h89);
    wait_sts(8'h01, "R10 wait", v);
    wr(0, 8'h00);
    chk(!scl_low && !sda_low, "R10 abort from hold", {scl_low, sda_low}, 0);
    wr(1, 0); wr(0, 8'h89);
    repeat (20) @(negedge clk);
    wr(0, 8'h00);
    chk(!scl_low && !sda_low, "R10 abort mid address", {scl_low, sda_low}, 0);
    repeat (200) @(negedge clk);
    rd(1, v); chk(v == 0, "R10 no phase flag after abort", v, 0);

    wr(0, 8'h90); chk(scl_low && sda_low, "R11 override both low", {scl_low, sda_low}, 3);
    wr(0, 8'hD0); chk(!scl_low && sda_low, "R11 override SCL released", {scl_low, sda_low}, 1);
    wr(0, 8'hB0); chk(scl_low && !sda_low, "R11 override SDA released", {scl_low, sda_low}, 2);
    wr(0, 8'hF0); chk(!scl_low && !sda_low, "R11 override both released", {scl_low, sda_low}, 0);
    wr(0, 8'h00);

    wr(1, 0); arb_force = 1'b1;
    wr(2, {SA, 1'b0}); wr(0, 8'h89);
    wait_sts(8'h20, "R9 wait", v);
    chk(v == 8'h20, "R9 arbitration flag only", v, 8'h20);
    chk(!scl_low && !sda_low, "R9 lines released", {scl_low, sda_low}, 0);
    arb_force = 1'b0;
    wr(1, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule